// File: doc/BRIEF.md
# Level/Edge Interrupt Source State Array

This block holds the trigger state of a bank of interrupt inputs and decides, for each input, when an event notification goes out to the router. Each source is set up once as either level-sensitive or edge/message-style. Every source keeps a two-bit PQ field: P means "notified and not yet acknowledged" and Q means "another trigger arrived meanwhile". Level sources also keep an asserted flag that follows their input line.

The block takes four kinds of event. Input line transitions come from the wires. A trigger request runs the edge rule on one source. An end-of-interrupt (EOI) request goes to one source. A software access reads one source's state and can optionally overwrite its PQ field. The result of a source's rules for the cycle can be a notification request. A small arbiter sends these requests out one at a time on a ready/valid port, with the source index. When the edge rule leaves a level source in the queued state, a one-cycle error pulse carries that source's index.

Top module: `irq_src_array`

## Requirements
- R1: After a synchronous reset every source reads PQ=01 (off) with the asserted flag clear. No notification and no error is presented.
- R2: The per-source level/edge type, written through the configuration port, is kept across reset.
- R3: When a level source's line rises, its asserted flag is set. Only from PQ=00 does PQ move to 10 and a notification for that source follow. From any other PQ nothing is notified.
- R4: When a level source's line falls, its asserted flag is cleared and no notification is produced.
- R5: For an edge source, a rising line or a trigger request applies the edge rule: 00 goes to 10 with a notification, 10 and 11 go to 11, and 01 stays 01. Only the first case notifies.
- R6: A falling line on an edge source leaves its state unchanged and produces no notification.
- R7: The EOI rule for an edge source: 00 and 10 go to 00 with no notification, 11 goes to 10 with a notification, and 01 stays 01.
- R8: For a level source that is still asserted after the EOI rule, the level rule runs again. From 10 this gives PQ=10 and a fresh notification.
- R9: If a trigger request leaves a level source at PQ=11, then err_valid pulses for one cycle, one cycle later, with err_idx set to that source.
- R10: A software access returns, one cycle later on sw_rdata, the state before the access: bit 2 is the asserted flag, bits 1:0 are PQ (P=bit 1, Q=bit 0). With sw_wr set it loads sw_pq. It never changes the asserted flag. With sw_wr clear the state is left alone.
- R11: Events for one source in the same cycle are applied in this order: line change, trigger request, EOI, software write. The software write takes precedence over all the others.
- R12: At most one notification is presented per cycle. Waiting requests go out lowest index first. A presented notification holds its index until notify_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Type map write strobe |
| cfg_idx | input | IDX_W | Source whose type is written |
| cfg_level | input | 1 | 1 = level-sensitive, 0 = edge/message |
| line_i | input | NUM_SRC | Interrupt input lines |
| trig_valid | input | 1 | Trigger request (edge rule) |
| trig_idx | input | IDX_W | Source of the trigger request |
| eoi_valid | input | 1 | End-of-interrupt request |
| eoi_idx | input | IDX_W | Source of the EOI |
| sw_valid | input | 1 | Software access strobe |
| sw_wr | input | 1 | Access also writes PQ |
| sw_idx | input | IDX_W | Source accessed |
| sw_pq | input | 2 | PQ value to load |
| sw_rvalid | output | 1 | sw_rdata is valid |
| sw_rdata | output | 3 | Previous {asserted, P, Q} |
| notify_valid | output | 1 | Notification presented |
| notify_idx | output | IDX_W | Source being notified |
| notify_ready | input | 1 | Receiver accepts the notification |
| err_valid | output | 1 | Queued state reached on a level source |
| err_idx | output | IDX_W | Source of the error |

## Verification
The hardest state to reach is a level source whose line is still high while its P bit is set. Only then does an EOI cause a fresh notification with no new line edge. The bench reaches it in steps: it clears PQ through the software port, raises the line to get the first notification, then drops and raises the line again so the asserted flag is set while PQ stays 10. Only then does it issue the EOI. For the collision order, the bench applies a line rise and an EOI to the same edge source in one cycle. The two possible orders leave different PQ values, and the bench reads PQ back to tell which one happened.

// File: rtl/irq_src_pkg.sv
`timescale 1ns/1ps
// Package irq_src_pkg
// Shared PQ encoding and the pure next-state rules used by every source.
// Assumes: rules are combinational and are chained in a fixed order by the caller.
package irq_src_pkg;

    typedef enum logic [1:0] {
        PQ_IDLE   = 2'b00,
        PQ_OFF    = 2'b01,
        PQ_PEND   = 2'b10,
        PQ_QUEUED = 2'b11
    } pq_e;

    typedef struct packed {
        pq_e  pq;
        logic fire;
    } step_t;

    // Edge/message trigger: notify from idle, coalesce into Q otherwise.
    function automatic step_t f_edge_trig(pq_e cur);
        step_t r;
        r.fire = 1'b0;
        case (cur)
            PQ_IDLE:   begin r.pq = PQ_PEND; r.fire = 1'b1; end
            PQ_PEND:   r.pq = PQ_QUEUED;
            PQ_QUEUED: r.pq = PQ_QUEUED;
            default:   r.pq = PQ_OFF;
        endcase
        return r;
    endfunction

    // End of interrupt: Q set means a retrigger.
    function automatic step_t f_eoi(pq_e cur);
        step_t r;
        r.fire = 1'b0;
        case (cur)
            PQ_QUEUED: begin r.pq = PQ_PEND; r.fire = 1'b1; end
            PQ_PEND:   r.pq = PQ_IDLE;
            PQ_IDLE:   r.pq = PQ_IDLE;
            default:   r.pq = PQ_OFF;
        endcase
        return r;
    endfunction

    // Level trigger: only P matters, fires from idle alone.
    function automatic step_t f_level_trig(pq_e cur);
        step_t r;
        r.fire = 1'b0;
        r.pq   = cur;
        if (cur == PQ_IDLE) begin
            r.pq   = PQ_PEND;
            r.fire = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_src_cell.sv
`timescale 1ns/1ps
// Module irq_src_cell
// State of one interrupt source: PQ field, asserted flag and static type bit.
// All events that hit the source in one cycle are chained in the order
// line change, trigger, EOI, software write.
// Assumes: rise and fall are never set together; the type bit is written
// at configuration time and is deliberately outside the reset.
module irq_src_cell
    import irq_src_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_hit,
    input  logic       cfg_level,
    input  logic       rise,
    input  logic       fall,
    input  logic       trig_hit,
    input  logic       eoi_hit,
    input  logic       sw_hit,
    input  logic       sw_wr,
    input  logic [1:0] sw_pq,
    output logic [1:0] pq_o,
    output logic       asrt_o,
    output logic       fire_o,
    output logic       err_o
);

    pq_e   pq_q, pq_d;
    logic  asrt_q, asrt_d;
    logic  is_level_q;
    step_t st_line, st_trig, st_eoi, st_relvl;
    pq_e   pq_a, pq_b, pq_c;

    // Type bit: written by configuration only, survives reset.
    always_ff @(posedge clk) begin
        if (cfg_hit) begin
            is_level_q <= cfg_level;
        end
    end

    // Next state: chain of line, trigger, EOI and software write.
    always_comb begin
        asrt_d  = asrt_q;
        fire_o  = 1'b0;
        err_o   = 1'b0;
        st_line = is_level_q ? f_level_trig(pq_q) : f_edge_trig(pq_q);
        pq_a    = pq_q;
        if (rise) begin
            pq_a   = st_line.pq;
            fire_o = st_line.fire;
            if (is_level_q) begin
                asrt_d = 1'b1;
            end
        end
        if (fall && is_level_q) begin
            asrt_d = 1'b0;
        end
        st_trig = f_edge_trig(pq_a);
        pq_b    = pq_a;
        if (trig_hit) begin
            pq_b = st_trig.pq;
            if (st_trig.fire) begin
                fire_o = 1'b1;
            end
            if (is_level_q && st_trig.pq == PQ_QUEUED) begin
                err_o = 1'b1;
            end
        end
        st_eoi   = f_eoi(pq_b);
        st_relvl = f_level_trig(st_eoi.pq);
        pq_c     = pq_b;
        if (eoi_hit) begin
            pq_c = st_eoi.pq;
            if (st_eoi.fire) begin
                fire_o = 1'b1;
            end
            if (is_level_q && asrt_d) begin
                pq_c = st_relvl.pq;
                if (st_relvl.fire) begin
                    fire_o = 1'b1;
                end
            end
        end
        pq_d = pq_c;
        if (sw_hit && sw_wr) begin
            pq_d = pq_e'(sw_pq);
        end
    end

    // State registers with synchronous reset to "off".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pq_q   <= PQ_OFF;
            asrt_q <= 1'b0;
        end else begin
            pq_q   <= pq_d;
            asrt_q <= asrt_d;
        end
    end

    assign pq_o   = pq_q;
    assign asrt_o = asrt_q;

    AST_RST_OFF: assert property (@(posedge clk) !rst_n |=> (pq_q == PQ_OFF && !asrt_q)); // R1
    AST_LVL_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n) (is_level_q && rise) |=> asrt_q); // R3
    AST_LVL_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (is_level_q && fall) |=> !asrt_q); // R4
    AST_SW_LOADS: assert property (@(posedge clk) disable iff (!rst_n) (sw_hit && sw_wr) |=> (pq_q == pq_e'($past(sw_pq)))); // R10

endmodule

// File: rtl/irq_notify_arb.sv
`timescale 1ns/1ps
// Module irq_notify_arb
// Collects per-source notification requests and presents them one at a
// time on a ready/valid port, lowest index first.
// Assumes: a new request for a source already waiting merges with it.
module irq_notify_arb #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic               ready,
    output logic               valid,
    output logic [IDX_W-1:0]   idx
);

    logic [NUM_SRC-1:0] pend_q, clr;
    logic               out_v_q, has, load;
    logic [IDX_W-1:0]   out_idx_q, pidx;

    // Lowest-index pick among the waiting requests.
    always_comb begin
        has  = 1'b0;
        pidx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                has  = 1'b1;
                pidx = IDX_W'(i);
            end
        end
        load = has && (!out_v_q || ready);
        clr  = '0;
        if (load) begin
            clr[pidx] = 1'b1;
        end
    end

    // Request bits and the output slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            out_v_q   <= 1'b0;
            out_idx_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr) | set_vec;
            if (!out_v_q || ready) begin
                out_v_q   <= has;
                out_idx_q <= pidx;
            end
        end
    end

    assign valid = out_v_q;
    assign idx   = out_idx_q;

    AST_NOTIFY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (valid && !ready) |=> (valid && $stable(idx))); // R12

endmodule

// File: rtl/irq_src_array.sv
`timescale 1ns/1ps
// Module irq_src_array
// Top of the source state array: finds line edges, steers the indexed
// requests to one cell each, and gathers notifications, errors and
// software read data.
// Assumes: at most one trigger, one EOI and one software access per cycle.
module irq_src_array
    import irq_src_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic               cfg_level,
    input  logic [NUM_SRC-1:0] line_i,
    input  logic               trig_valid,
    input  logic [IDX_W-1:0]   trig_idx,
    input  logic               eoi_valid,
    input  logic [IDX_W-1:0]   eoi_idx,
    input  logic               sw_valid,
    input  logic               sw_wr,
    input  logic [IDX_W-1:0]   sw_idx,
    input  logic [1:0]         sw_pq,
    output logic               sw_rvalid,
    output logic [2:0]         sw_rdata,
    output logic               notify_valid,
    output logic [IDX_W-1:0]   notify_idx,
    input  logic               notify_ready,
    output logic               err_valid,
    output logic [IDX_W-1:0]   err_idx
);

    logic [NUM_SRC-1:0] line_q, rise_v, fall_v, fire_v, err_v, asrt_v;
    logic [1:0]         pq_v [NUM_SRC];
    logic               err_any;
    logic [IDX_W-1:0]   err_pick;

    // Previous line values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_i;
        end
    end

    assign rise_v = line_i & ~line_q;
    assign fall_v = ~line_i & line_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_src_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_hit   (cfg_we && cfg_idx == IDX_W'(g)),
            .cfg_level (cfg_level),
            .rise      (rise_v[g]),
            .fall      (fall_v[g]),
            .trig_hit  (trig_valid && trig_idx == IDX_W'(g)),
            .eoi_hit   (eoi_valid && eoi_idx == IDX_W'(g)),
            .sw_hit    (sw_valid && sw_idx == IDX_W'(g)),
            .sw_wr     (sw_wr),
            .sw_pq     (sw_pq),
            .pq_o      (pq_v[g]),
            .asrt_o    (asrt_v[g]),
            .fire_o    (fire_v[g]),
            .err_o     (err_v[g])
        );
    end

    irq_notify_arb #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (fire_v),
        .ready   (notify_ready),
        .valid   (notify_valid),
        .idx     (notify_idx)
    );

    // Encode the source that raised the error this cycle.
    always_comb begin
        err_any  = |err_v;
        err_pick = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (err_v[i]) begin
                err_pick = IDX_W'(i);
            end
        end
    end

    // Registered error pulse and software read-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_idx   <= '0;
            sw_rvalid <= 1'b0;
            sw_rdata  <= 3'b000;
        end else begin
            err_valid <= err_any;
            err_idx   <= err_pick;
            sw_rvalid <= sw_valid;
            if (sw_valid) begin
                sw_rdata <= {asrt_v[sw_idx], pq_v[sw_idx]};
            end
        end
    end

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) err_valid |-> $past(trig_valid)); // R9
    AST_ONE_ERR: assert property (@(posedge clk) disable iff (!rst_n) $countones(err_v) <= 1); // R9

endmodule

// File: tb/test_irq_src_array.sv
`timescale 1ns/1ps
module test_irq_src_array;

    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0, cfg_level = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [N-1:0]  line_i = '0;
    logic          trig_valid = 1'b0, eoi_valid = 1'b0, sw_valid = 1'b0, sw_wr = 1'b0;
    logic [IW-1:0] trig_idx = '0, eoi_idx = '0, sw_idx = '0;
    logic [1:0]    sw_pq = '0;
    logic          sw_rvalid, notify_valid, err_valid;
    logic [2:0]    sw_rdata;
    logic [IW-1:0] notify_idx, err_idx;
    logic          notify_ready = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_src_array #(.NUM_SRC(N)) i_irq_src_array (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_level(cfg_level),
        .line_i(line_i), .trig_valid(trig_valid), .trig_idx(trig_idx),
        .eoi_valid(eoi_valid), .eoi_idx(eoi_idx), .sw_valid(sw_valid), .sw_wr(sw_wr),
        .sw_idx(sw_idx), .sw_pq(sw_pq), .sw_rvalid(sw_rvalid), .sw_rdata(sw_rdata),
        .notify_valid(notify_valid), .notify_idx(notify_idx), .notify_ready(notify_ready),
        .err_valid(err_valid), .err_idx(err_idx)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Software access: state before the access is returned.
    task automatic sw_acc(int idx, bit wr, int pq, output int old);
        sw_valid = 1'b1; sw_wr = wr; sw_idx = IW'(idx); sw_pq = 2'(pq);
        @(negedge clk);
        sw_valid = 1'b0; sw_wr = 1'b0;
        old = {29'd0, sw_rdata};
    endtask

    task automatic rd_chk(string tag, int idx, int exp);
        int v;
        sw_acc(idx, 1'b0, 0, v);
        chk(tag, v, exp);
    endtask

    task automatic set_line(int idx, bit v);
        line_i[idx] = v;
        @(negedge clk);
    endtask

    task automatic do_eoi(int idx);
        eoi_valid = 1'b1; eoi_idx = IW'(idx);
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    // One cycle later than the event: notification slot content.
    task automatic note_chk(string tag, bit v, int idx);
        @(negedge clk);
        chk({tag, " notify_valid"}, notify_valid, v);
        if (v) chk({tag, " notify_idx"}, notify_idx, idx);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 notify idle", notify_valid, 0);
        chk("R1 err idle", err_valid, 0);
        for (int i = 0; i < N; i++) rd_chk("R1 pq off", i, 3'b001);
    endtask

    task automatic t_level_rise();
        int v;
        sw_acc(1, 1'b1, 2'b00, v);
        chk("R10 old value", v, 3'b001);
        set_line(1, 1'b1);
        note_chk("R3 level rise", 1'b1, 1);
        rd_chk("R2 R3 level asserted+P", 1, 3'b110);
        set_line(1, 1'b0);
        note_chk("R4 level fall", 1'b0, 0);
        rd_chk("R4 flag cleared", 1, 3'b010);
        set_line(2, 1'b1);
        note_chk("R3 rise while off", 1'b0, 0);
        rd_chk("R3 off asserted", 2, 3'b101);
    endtask

    task automatic t_level_eoi();
        set_line(1, 1'b1);
        note_chk("R3 rise with P set", 1'b0, 0);
        rd_chk("R3 P kept", 1, 3'b110);
        do_eoi(1);
        note_chk("R8 re-fire", 1'b1, 1);
        rd_chk("R8 state", 1, 3'b110);
        set_line(1, 1'b0);
        do_eoi(1);
        note_chk("R8 no re-fire when low", 1'b0, 0);
        rd_chk("R8 idle", 1, 3'b000);
    endtask

    task automatic t_edge();
        int v;
        sw_acc(5, 1'b1, 2'b00, v);
        set_line(5, 1'b1);
        note_chk("R5 edge from idle", 1'b1, 5);
        rd_chk("R5 pending", 5, 3'b010);
        set_line(5, 1'b0);
        note_chk("R6 fall ignored", 1'b0, 0);
        rd_chk("R6 state kept", 5, 3'b010);
        set_line(5, 1'b1);
        note_chk("R5 coalesce", 1'b0, 0);
        rd_chk("R5 queued", 5, 3'b011);
        do_eoi(5);
        note_chk("R7 retrigger", 1'b1, 5);
        rd_chk("R7 back to P", 5, 3'b010);
        do_eoi(5);
        note_chk("R7 plain eoi", 1'b0, 0);
        rd_chk("R7 idle", 5, 3'b000);
        sw_acc(5, 1'b1, 2'b01, v);
        set_line(5, 1'b0);
        set_line(5, 1'b1);
        note_chk("R5 off no notify", 1'b0, 0);
        rd_chk("R5 off kept", 5, 3'b001);
        do_eoi(5);
        rd_chk("R7 off kept", 5, 3'b001);
    endtask

    task automatic t_error();
        int v;
        sw_acc(3, 1'b1, 2'b10, v);
        trig_valid = 1'b1; trig_idx = 3'd3;
        @(negedge clk);
        trig_valid = 1'b0;
        chk("R9 err_valid", err_valid, 1);
        chk("R9 err_idx", err_idx, 3);
        @(negedge clk);
        chk("R9 one pulse", err_valid, 0);
        sw_acc(6, 1'b1, 2'b10, v);
        trig_valid = 1'b1; trig_idx = 3'd6;
        @(negedge clk);
        trig_valid = 1'b0;
        chk("R9 no err on edge source", err_valid, 0);
        rd_chk("R5 trigger queues", 6, 3'b011);
    endtask

    task automatic t_sw();
        int v;
        rd_chk("R10 read only", 2, 3'b101);
        rd_chk("R10 read again", 2, 3'b101);
        sw_acc(2, 1'b1, 2'b00, v);
        chk("R10 write returns old", v, 3'b101);
        note_chk("R10 write no notify", 1'b0, 0);
        rd_chk("R10 flag untouched", 2, 3'b100);
    endtask

    task automatic t_order();
        int v;
        sw_acc(6, 1'b1, 2'b00, v);
        line_i[6] = 1'b1; eoi_valid = 1'b1; eoi_idx = 3'd6;
        @(negedge clk);
        eoi_valid = 1'b0;
        note_chk("R11 line before eoi", 1'b1, 6);
        rd_chk("R11 eoi applied last", 6, 3'b000);
        trig_valid = 1'b1; trig_idx = 3'd6;
        sw_valid = 1'b1; sw_wr = 1'b1; sw_idx = 3'd6; sw_pq = 2'b01;
        @(negedge clk);
        trig_valid = 1'b0; sw_valid = 1'b0; sw_wr = 1'b0;
        rd_chk("R11 sw write wins", 6, 3'b001);
        @(negedge clk);
    endtask

    task automatic t_arb();
        int v;
        sw_acc(4, 1'b1, 2'b00, v);
        sw_acc(7, 1'b1, 2'b00, v);
        notify_ready = 1'b0;
        line_i[4] = 1'b1; line_i[7] = 1'b1;
        @(negedge clk);
        note_chk("R12 lowest first", 1'b1, 4);
        @(negedge clk);
        chk("R12 held valid", notify_valid, 1);
        chk("R12 held idx", notify_idx, 4);
        notify_ready = 1'b1;
        @(negedge clk);
        chk("R12 second valid", notify_valid, 1);
        chk("R12 second idx", notify_idx, 7);
        @(negedge clk);
        chk("R12 drained", notify_valid, 0);
    endtask

    task automatic configure();
        for (int i = 0; i < N; i++) begin
            cfg_we = 1'b1; cfg_idx = IW'(i); cfg_level = (i < 4);
            @(negedge clk);
        end
        cfg_we = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        configure();
        t_reset();
        do_reset();
        t_level_rise();
        t_level_eoi();
        t_edge();
        t_error();
        t_sw();
        t_order();
        t_arb();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule